// File: doc/BRIEF.md
# I2C DAC Update Front End

This block is the serial receive side of a four-channel 8-bit converter. It watches the I2C clock and data lines, which are already synchronised to the system clock, and drives an enable that pulls the shared data line low when it acknowledges. Two addresses select it. The first is its own device address, a fixed 5-bit prefix followed by two select bits. The second is a broadcast address that lets one master update several converters at the same moment.

A write frame starts with the address byte and then a control byte. After that come one or more pairs of data bytes. The control byte stays in force until the frame ends, so each further update costs only one byte pair. The first byte of a pair is the new 8-bit value. The second byte is clocked in and acknowledged, but its content is never used.

The update appears as a one-cycle strobe that carries the value and the current control byte. The strobe is valid-only and has no ready signal. The bus cannot be stalled, so the consumer must take every strobe in the cycle it appears. A small holding register bank inside the block takes each strobe, and the two low control bits pick which channel register is written.

Top module: `dac_i2c_front`

## Requirements
- R1: The address byte is acknowledged when its upper seven bits equal `10011` followed by the two captured select bits, with the R/W bit (bit 0) equal to 0 for writes. `sda_pull_o` is high throughout the high phase of the ninth SCL pulse.
- R2: The select bits are taken from `sel_i` in the first clock after reset is released. Changes on `sel_i` after that have no effect on address matching.
- R3: The broadcast address (parameter, default `1001000`) is acknowledged when R/W = 0, whatever the select bits are. With R/W = 1 it is not acknowledged.
- R4: An address byte that matches neither address gets no acknowledge. Every later byte in that frame also gets no acknowledge and produces no strobe.
- R5: In a write frame, the control byte, the MSB byte and the LSB byte are each acknowledged. `upd_valid_o` goes high for exactly one clock after the SCL falling edge that ends the acknowledge of the LSB byte. At that moment `upd_data_o` equals the MSB byte and `upd_ctrl_o` equals the control byte. The value of the LSB byte has no effect.
- R6: After the first update, each further MSB/LSB pair in the same frame produces one more strobe using the same control byte. Consecutive strobes are exactly 18 SCL rising edges apart.
- R7: Control bits [1:0] select channel register 0 to 3. The selected register takes `upd_data_o` one clock after the strobe, and the other channel registers keep their values. The bank is presented on `chan_o`, with channel k at bits [8k+7:8k].
- R8: After a STOP the block releases SDA. It acknowledges nothing and produces no strobe until the next START.
- R9: A repeated START in the middle of a frame restarts address reception, and a new control byte is then expected.
- R10: A read addressed to the device address is acknowledged at the address stage only. After that the block never pulls SDA low in that frame.
- R11: A broadcast write that ends before a full data-byte pair has been received produces no strobe.
- R12: During and right after reset, `sda_pull_o` and `upd_valid_o` are low and every channel register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA line level |
| sel_i | input | 2 | Address select bits, captured once after reset |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| upd_valid_o | output | 1 | One-cycle update strobe, no back-pressure |
| upd_data_o | output | 8 | Update value (MSB byte) |
| upd_ctrl_o | output | 8 | Control byte in force for the update |
| chan_o | output | 32 | Channel holding registers, channel k at [8k+7:8k] |

## Verification
The bench checks that the select bits stay frozen after reset. A design that re-sampled them would start to acknowledge the new address. It tests a broadcast read, which a loose match would acknowledge, and a broadcast frame with no data pair, where a design that strobed early would produce a stray update. It also checks the 18-edge spacing between updates in one frame. A design that expected the control byte again, or latched on the wrong acknowledge edge, would break that spacing. Further cases cover traffic after a STOP, a repeated START, and data bytes after a read acknowledge, because a design that kept decoding in any of these would pull SDA low or strobe when it should not.

// File: rtl/dac_i2c_pkg.sv
package dac_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CTRL,
    ST_MSB,
    ST_LSB
  } rx_state_t;
endpackage

// File: rtl/dac_i2c_linecond.sv
module dac_i2c_linecond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise = scl_i & ~scl_q;
  assign scl_fall = ~scl_i & scl_q;
  assign start_c  = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_c   = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/dac_i2c_engine.sv
module dac_i2c_engine
  import dac_i2c_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          SEL_W       = 2,
  parameter logic [6:0]  BCAST_ADDR  = 7'b1001000,
  parameter logic [4:0]  DEV_PREFIX  = 5'b10011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_c,
  input  logic             stop_c,
  output logic             sda_pull,
  output logic             upd_v,
  output logic [DW-1:0]    upd_data,
  output logic [DW-1:0]    upd_ctrl
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);

  rx_state_t        st;
  logic [CNT_W-1:0] bitcnt;
  logic             ackph;
  logic [DW-1:0]    shreg;
  logic [SEL_W-1:0] sel_q;
  logic             armed;
  logic             addr_ok;

  assign addr_ok = (shreg[7:1] == {DEV_PREFIX, sel_q}) ||
                   (shreg[7:1] == BCAST_ADDR && !shreg[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      ackph    <= 1'b0;
      sda_pull <= 1'b0;
      shreg    <= '0;
      sel_q    <= '0;
      armed    <= 1'b0;
      upd_v    <= 1'b0;
      upd_data <= '0;
      upd_ctrl <= '0;
    end else begin
      upd_v <= 1'b0;
      if (!armed) begin
        sel_q <= sel_i;
        armed <= 1'b1;
      end
      if (start_c) begin
        st       <= ST_ADDR;
        bitcnt   <= '0;
        ackph    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_c) begin
        st       <= ST_IDLE;
        bitcnt   <= '0;
        ackph    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise && bitcnt != FULL && !ackph) begin
          shreg  <= {shreg[DW-2:0], sda_i};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall && bitcnt == FULL && !ackph) begin
          if (st == ST_ADDR && !addr_ok) begin
            st     <= ST_IDLE;
            bitcnt <= '0;
          end else begin
            ackph    <= 1'b1;
            sda_pull <= 1'b1;
          end
        end else if (scl_fall && ackph) begin
          ackph    <= 1'b0;
          sda_pull <= 1'b0;
          bitcnt   <= '0;
          case (st)
            ST_ADDR: st <= shreg[0] ? ST_IDLE : ST_CTRL;
            ST_CTRL: begin
              upd_ctrl <= shreg;
              st       <= ST_MSB;
            end
            ST_MSB: begin
              upd_data <= shreg;
              st       <= ST_LSB;
            end
            ST_LSB: begin
              upd_v <= 1'b1;
              st    <= ST_MSB;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/dac_i2c_chbank.sv
module dac_i2c_chbank #(
  parameter int DW  = 8,
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_v,
  input  logic [DW-1:0]     wr_ctrl,
  input  logic [DW-1:0]     wr_data,
  output logic [NCH*DW-1:0] chan
);
  localparam int CS_W = $clog2(NCH);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        chan[k*DW +: DW] <= '0;
      else if (wr_v && wr_ctrl[CS_W-1:0] == CS_W'(k))
        chan[k*DW +: DW] <= wr_data;
    end
  end
endmodule

// File: rtl/dac_i2c_front.sv
module dac_i2c_front #(
  parameter int         DW         = 8,
  parameter int         NCH        = 4,
  parameter int         SEL_W      = 2,
  parameter logic [6:0] BCAST_ADDR = 7'b1001000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              sda_pull_o,
  output logic              upd_valid_o,
  output logic [DW-1:0]     upd_data_o,
  output logic [DW-1:0]     upd_ctrl_o,
  output logic [NCH*DW-1:0] chan_o
);
  logic scl_rise, scl_fall, start_c, stop_c;

  dac_i2c_linecond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c)
  );

  dac_i2c_engine #(
    .DW(DW), .SEL_W(SEL_W), .BCAST_ADDR(BCAST_ADDR), .DEV_PREFIX(5'b10011)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_i(sda_i), .sel_i(sel_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_c(start_c), .stop_c(stop_c),
    .sda_pull(sda_pull_o), .upd_v(upd_valid_o),
    .upd_data(upd_data_o), .upd_ctrl(upd_ctrl_o)
  );

  dac_i2c_chbank #(.DW(DW), .NCH(NCH)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_v(upd_valid_o),
    .wr_ctrl(upd_ctrl_o), .wr_data(upd_data_o), .chan(chan_o)
  );
endmodule

// File: rtl/dac_i2c_front_chk.sv
module dac_i2c_front_chk #(
  parameter int DW    = 8,
  parameter int NCH   = 4,
  parameter int SEL_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic              sda_pull_o,
  input logic              upd_valid_o,
  input logic [DW-1:0]     upd_data_o,
  input logic [DW-1:0]     upd_ctrl_o,
  input logic [NCH*DW-1:0] chan_o
);
  localparam int CS_W = $clog2(NCH);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_o |=> !upd_valid_o);

  // R5
  strobe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_o |-> !scl_i);

  // R7
  bank_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid_o |=> chan_o[DW*$past(upd_ctrl_o[CS_W-1:0]) +: DW] == $past(upd_data_o));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_pull_o);

  // R1
  pull_change_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_i);
endmodule

bind dac_i2c_front dac_i2c_front_chk #(.DW(DW), .NCH(NCH), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_dac_i2c_front.sv
module tb_dac_i2c_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  sel_i = 2'b10;
  logic        sda_pull_o, upd_valid_o;
  logic [7:0]  upd_data_o, upd_ctrl_o;
  logic [31:0] chan_o;
  wire         sda_line = sda_m & ~sda_pull_o;

  int errs = 0, checks = 0, n_upd = 0, rises = 0;
  int upd_at [16];
  logic [7:0] last_data, last_ctrl;
  logic [7:0] exp_ch [4] = '{8'h00, 8'h00, 8'h00, 8'h00};
  bit done = 0;

  always #2 clk = ~clk;

  dac_i2c_front dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sel_i(sel_i),
    .sda_pull_o(sda_pull_o), .upd_valid_o(upd_valid_o),
    .upd_data_o(upd_data_o), .upd_ctrl_o(upd_ctrl_o), .chan_o(chan_o)
  );

  always @(posedge scl_m) rises++;
  always @(negedge clk) if (rst_n && upd_valid_o) begin
    if (n_upd < 16) upd_at[n_upd] = rises;
    n_upd++;
    last_data = upd_data_o;
    last_ctrl = upd_ctrl_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; wt(2); scl_m = 1'b1; wt(4);
    sda_m = 1'b0; wt(4); scl_m = 1'b0; wt(2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wt(2); scl_m = 1'b1; wt(4); sda_m = 1'b1; wt(6);
  endtask

  task automatic i2c_bit(input logic b, output logic pulled);
    wt(1); sda_m = b; wt(3);
    scl_m = 1'b1; wt(2); pulled = sda_pull_o; wt(2);
    scl_m = 1'b0;
  endtask

  task automatic i2c_byte(input logic [7:0] v, output logic ack);
    logic p;
    for (int i = 7; i >= 0; i--) i2c_bit(v[i], p);
    i2c_bit(1'b1, ack);
  endtask

  localparam logic [31:0] VEC [4] = '{
    {8'h9C, 8'h00, 8'h11, 8'hFF},
    {8'h9C, 8'h03, 8'hA5, 8'h00},
    {8'h90, 8'h01, 8'h3C, 8'h55},
    {8'h9C, 8'h02, 8'hF0, 8'h0F}
  };

  initial begin : main
    logic a0, a1, a2, a3;
    int   base;
    wt(3);
    // R12 reset state
    chk(sda_pull_o == 0 && upd_valid_o == 0, "R12", {sda_pull_o, upd_valid_o}, 0);
    chk(chan_o == 32'h0, "R12", chan_o, 0);
    rst_n = 1'b1; wt(4);
    chk(chan_o == 32'h0 && sda_pull_o == 0, "R12", chan_o, 0);

    // vector table: R1 R3 R5 R7
    for (int v = 0; v < 4; v++) begin
      base = n_upd;
      i2c_start();
      i2c_byte(VEC[v][31:24], a0); i2c_byte(VEC[v][23:16], a1);
      i2c_byte(VEC[v][15:8], a2);  i2c_byte(VEC[v][7:0], a3);
      i2c_stop();
      exp_ch[VEC[v][17:16]] = VEC[v][15:8];
      chk({a0, a1, a2, a3} == 4'hF, "R1/R5 acks", {a0, a1, a2, a3}, 4'hF);
      chk(n_upd == base + 1, "R5 strobe count", n_upd - base, 1);
      chk(last_data == VEC[v][15:8] && last_ctrl == VEC[v][23:16], "R5 data/ctrl",
          {last_data, last_ctrl}, VEC[v][23:8]);
      chk(chan_o == {exp_ch[3], exp_ch[2], exp_ch[1], exp_ch[0]}, "R7 bank",
          chan_o, {exp_ch[3], exp_ch[2], exp_ch[1], exp_ch[0]});
    end

    // R6 repeated pairs, 18 SCL rising edges apart
    base = n_upd;
    i2c_start();
    i2c_byte(8'h9C, a0); i2c_byte(8'h01, a1);
    i2c_byte(8'h21, a2); i2c_byte(8'h00, a3);
    i2c_byte(8'h42, a2); i2c_byte(8'h00, a3);
    i2c_byte(8'h63, a2); i2c_byte(8'h00, a3);
    i2c_stop();
    exp_ch[1] = 8'h63;
    chk(n_upd == base + 3, "R6 count", n_upd - base, 3);
    chk(upd_at[base + 1] - upd_at[base] == 18, "R6 spacing1", upd_at[base + 1] - upd_at[base], 18);
    chk(upd_at[base + 2] - upd_at[base + 1] == 18, "R6 spacing2", upd_at[base + 2] - upd_at[base + 1], 18);
    chk(last_data == 8'h63 && last_ctrl == 8'h01, "R6 ctrl kept", {last_data, last_ctrl}, 16'h6301);

    // R4 non-matching address
    base = n_upd;
    i2c_start();
    i2c_byte(8'h98, a0); i2c_byte(8'h00, a1); i2c_byte(8'h77, a2); i2c_byte(8'h00, a3);
    i2c_stop();
    chk(!a0 && !a1 && !a2 && !a3, "R4 no ack", {a0, a1, a2, a3}, 0);
    chk(n_upd == base, "R4 no strobe", n_upd - base, 0);

    // R3 broadcast read not acknowledged
    i2c_start(); i2c_byte(8'h91, a0); i2c_stop();
    chk(!a0, "R3 bcast read", a0, 0);

    // R11 broadcast write without data pair
    base = n_upd;
    i2c_start(); i2c_byte(8'h90, a0); i2c_byte(8'h02, a1); i2c_byte(8'h55, a2); i2c_stop();
    chk(a0 && a1 && a2 && n_upd == base, "R11 no strobe", n_upd - base, 0);

    // R10 device read: ack at address only
    i2c_start(); i2c_byte(8'h9D, a0); i2c_byte(8'hFF, a1); i2c_byte(8'hFF, a2); i2c_stop();
    chk(a0 && !a1 && !a2, "R10 read", {a0, a1, a2}, 4);

    // R8 bytes after STOP are ignored
    base = n_upd;
    i2c_byte(8'h9C, a0); i2c_byte(8'h00, a1); i2c_byte(8'h12, a2); i2c_byte(8'h00, a3);
    chk(!a0 && !a1 && !a2 && !a3 && n_upd == base, "R8 after stop", {a0, a1, a2, a3}, 0);
    chk(chan_o[7:0] == exp_ch[0], "R8 bank kept", chan_o[7:0], exp_ch[0]);

    // R9 repeated start restarts address reception
    base = n_upd;
    i2c_start(); i2c_byte(8'h9C, a0); i2c_byte(8'h03, a1);
    i2c_start(); i2c_byte(8'h9C, a0); i2c_byte(8'h02, a1);
    i2c_byte(8'h5A, a2); i2c_byte(8'h00, a3); i2c_stop();
    exp_ch[2] = 8'h5A;
    chk(n_upd == base + 1 && last_ctrl == 8'h02 && last_data == 8'h5A, "R9 restart",
        {last_ctrl, last_data}, 16'h025A);
    chk(chan_o == {exp_ch[3], exp_ch[2], exp_ch[1], exp_ch[0]}, "R9 bank",
        chan_o, {exp_ch[3], exp_ch[2], exp_ch[1], exp_ch[0]});

    // R2 select bits frozen after reset
    sel_i = 2'b01; wt(4);
    i2c_start(); i2c_byte(8'h9A, a0); i2c_stop();
    chk(!a0, "R2 new sel ignored", a0, 0);
    i2c_start(); i2c_byte(8'h9C, a0); i2c_stop();
    chk(a0, "R2 old sel kept", a0, 1);

    // R1 acknowledge held across ninth high phase (sampled mid-high above); idle after
    wt(4);
    chk(!sda_pull_o && !upd_valid_o, "R1 idle release", sda_pull_o, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule